// File: doc/BRIEF.md
# Downstream Port Power and Indicator Controller

This block sits beside the per-port state machines of a hub and drives the external power switches and the two-colour status lamps of up to four downstream ports. Each port takes a power request, its connect, enable and error status, an active-low over-current flag, a clear pulse for its over-current change flag, and a lamp command. The block turns these into switch enables, green and amber lamp drives, and a sticky over-current change flag per port.

Two board-level settings shape the outputs. In individual mode each port owns its switch and its flag. In gang mode the first port's switch output powers every port and the first port's flag protects every port. A polarity strap sets whether an asserted enable is high or low. A port-count input retires the upper ports, and a global-suspend input darkens every lamp. Over-current flags pass through a two-flop synchroniser and a programmable low-time filter before they cut power. A port that has been tripped stays unpowered until its request is withdrawn.

Top module: `hpl_port_power_led`

## Requirements
- R1: While rst_n is low at a clock edge, every power enable sits at its deasserted level, every lamp is dark and every change flag is 0.
- R2: pwr_pol_i = 1 makes an asserted enable read 1 and a deasserted one read 0. pwr_pol_i = 0 inverts both levels. The output follows the strap in the same cycle.
- R3: In individual mode (gang_mode_i = 0), the enable of an active port asserts one cycle after its pwr_req_i bit rises and deasserts one cycle after it falls.
- R4: In gang mode (gang_mode_i = 1), output bit 0 asserts when any active port requests power, and outputs 1 and up stay deasserted.
- R5: Ports with index at or above the effective port count keep their enable deasserted and their lamps dark. port_cnt_i below 2 counts as 2, and above the number of ports it counts as that number.
- R6: An over-current input is synchronised through two flops. It is accepted only once its synchronised value has been 0 for oc_filt_i + 1 consecutive samples (oc_filt_i = 0 acts as 1). Shorter pulses have no effect.
- R7: An accepted over-current removes power from its port, or from the shared enable in gang mode. Power stays off after the flag goes away, until the request is withdrawn: in gang mode, until no active port requests power.
- R8: The onset of an accepted over-current sets the change flag of its port. In gang mode, port 0's flag sets the change flags of all active ports. A flag stays set until its oc_chg_clr_i bit is high for a cycle, and a new onset wins over a clear.
- R9: With led_man_i low, a port's lamp, one cycle after its inputs, is amber while the port sees an accepted over-current or err_i is high. Otherwise it is green when conn_i and enab_i are both high, and dark in all other cases.
- R10: With led_man_i high, the port's two bits led_cmd_i[2i+1:2i] select the lamp one cycle later: 01 green, 10 amber, 00 or 11 dark.
- R11: One cycle after suspend_i is high, every lamp is dark, whatever the mode or command.
- R12: A port's green and amber drives are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gang_mode_i | input | 1 | 1 = ganged switch and flag, 0 = per-port |
| pwr_pol_i | input | 1 | Enable polarity: 1 active-high, 0 active-low |
| port_cnt_i | input | 3 | Number of ports in use (2..4) |
| oc_filt_i | input | 8 | Over-current filter length in cycles |
| suspend_i | input | 1 | Global suspend, darkens all lamps |
| pwr_req_i | input | 4 | Per-port power request |
| conn_i | input | 4 | Per-port device connected |
| enab_i | input | 4 | Per-port enabled |
| err_i | input | 4 | Per-port error |
| oc_n_i | input | 4 | Per-port over-current, active low, asynchronous |
| oc_chg_clr_i | input | 4 | Per-port clear of the change flag |
| led_man_i | input | 4 | Per-port manual lamp mode |
| led_cmd_i | input | 8 | Per-port manual lamp command, 2 bits each |
| pwr_en_o | output | 4 | Power switch enables |
| led_green_o | output | 4 | Green lamp drives |
| led_amber_o | output | 4 | Amber lamp drives |
| oc_chg_o | output | 4 | Sticky over-current change flags |

## Verification
The bench builds the block with its defaults: four ports and an 8-bit filter length. Four ports let the random phase reach every effective count, including clamping from 0, 1 and 5 to 7, in both strap polarities and both power modes. Filter lengths of 1 and 5 bring the acceptance edge within a few cycles. This lets the bench place pulses one sample short of and one sample past the threshold, then follow a trip through release, clear and request withdrawal in both modes.

// File: rtl/hpl_pkg.sv
// Shared lamp encoding and the decode of a manual lamp command.
// Assumes a two-bit command per port: 01 green, 10 amber, others dark.
package hpl_pkg;
    typedef enum logic [1:0] {
        LAMP_DARK  = 2'b00,
        LAMP_GREEN = 2'b01,
        LAMP_AMBER = 2'b10
    } lamp_e;

    function automatic lamp_e decode_cmd(input logic [1:0] cmd);
        case (cmd)
            2'b01:   return LAMP_GREEN;
            2'b10:   return LAMP_AMBER;
            default: return LAMP_DARK;
        endcase
    endfunction
endpackage

// File: rtl/hpl_oc_filter.sv
// Synchronises one active-low over-current flag and accepts it only after
// it has stayed low for len+1 synchronised samples (len of 0 acts as 1).
// Assumes the raw flag is asynchronous to clk.
module hpl_oc_filter #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oc_n,
    input  logic [FW-1:0] len,
    output logic          hit
);
    logic          sync1, sync2;
    logic [FW-1:0] run_cnt;
    logic [FW-1:0] len_eff;

    assign len_eff = (len == '0) ? FW'(1) : len;

    // two-flop synchroniser, idle high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= oc_n;
            sync2 <= sync1;
        end
    end

    // count consecutive low samples, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n)                run_cnt <= '0;
        else if (sync2)            run_cnt <= '0;
        else if (run_cnt < len_eff) run_cnt <= run_cnt + FW'(1);
    end

    assign hit = !sync2 && (run_cnt >= len_eff);
endmodule

// File: rtl/hpl_port_ctl.sv
// Per-port power, trip latch, change flag and lamp register.
// Assumes req_eff already folds in gang mode and port activity.
module hpl_port_ctl
    import hpl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       suspend,
    input  logic       req_eff,
    input  logic       oc_eff,
    input  logic       conn,
    input  logic       enab,
    input  logic       err,
    input  logic       man,
    input  logic [1:0] cmd,
    input  logic       clr,
    output logic       pwr_on,
    output logic       green,
    output logic       amber,
    output logic       chg
);
    logic  trip_q;
    logic  oc_seen_q;
    logic  oc_live;
    lamp_e lamp_nx;

    assign oc_live = oc_eff && active;

    // trip latch: set by over-current, released when the request drops
    always_ff @(posedge clk) begin
        if (!rst_n)       trip_q <= 1'b0;
        else if (oc_live) trip_q <= 1'b1;
        else if (!req_eff) trip_q <= 1'b0;
    end

    // registered switch state
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_on <= 1'b0;
        else        pwr_on <= req_eff && !oc_live && !trip_q;
    end

    // onset detection and sticky change flag, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_seen_q <= 1'b0;
            chg       <= 1'b0;
        end else begin
            oc_seen_q <= oc_live;
            if (oc_live && !oc_seen_q) chg <= 1'b1;
            else if (clr)              chg <= 1'b0;
        end
    end

    // next lamp colour from suspend, activity, mode and status
    always_comb begin
        if (!active || suspend)  lamp_nx = LAMP_DARK;
        else if (man)            lamp_nx = decode_cmd(cmd);
        else if (oc_live || err) lamp_nx = LAMP_AMBER;
        else if (conn && enab)   lamp_nx = LAMP_GREEN;
        else                     lamp_nx = LAMP_DARK;
    end

    // registered lamp drives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            green <= 1'b0;
            amber <= 1'b0;
        end else begin
            green <= (lamp_nx == LAMP_GREEN);
            amber <= (lamp_nx == LAMP_AMBER);
        end
    end
endmodule

// File: rtl/hpl_port_power_led.sv
// Downstream port power and lamp controller, individual or gang mode.
// Assumes straps are quasi-static and port state inputs are synchronous.
module hpl_port_power_led #(
    parameter int NPORT = 4,
    parameter int FW    = 8,
    localparam int CW   = $clog2(NPORT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gang_mode_i,
    input  logic               pwr_pol_i,
    input  logic [CW-1:0]      port_cnt_i,
    input  logic [FW-1:0]      oc_filt_i,
    input  logic               suspend_i,
    input  logic [NPORT-1:0]   pwr_req_i,
    input  logic [NPORT-1:0]   conn_i,
    input  logic [NPORT-1:0]   enab_i,
    input  logic [NPORT-1:0]   err_i,
    input  logic [NPORT-1:0]   oc_n_i,
    input  logic [NPORT-1:0]   oc_chg_clr_i,
    input  logic [NPORT-1:0]   led_man_i,
    input  logic [2*NPORT-1:0] led_cmd_i,
    output logic [NPORT-1:0]   pwr_en_o,
    output logic [NPORT-1:0]   led_green_o,
    output logic [NPORT-1:0]   led_amber_o,
    output logic [NPORT-1:0]   oc_chg_o
);
    logic [CW-1:0]    cnt_eff;
    logic [NPORT-1:0] active;
    logic [NPORT-1:0] hit;
    logic [NPORT-1:0] oc_eff;
    logic [NPORT-1:0] req_eff;
    logic [NPORT-1:0] pwr_on;
    logic             req_any;

    // clamp the configured port count into 2..NPORT
    always_comb begin
        if (port_cnt_i < CW'(2))          cnt_eff = CW'(2);
        else if (port_cnt_i > CW'(NPORT)) cnt_eff = CW'(NPORT);
        else                              cnt_eff = port_cnt_i;
    end

    assign req_any = |(pwr_req_i & active);

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign active[i]  = (CW'(i) < cnt_eff);
        assign oc_eff[i]  = gang_mode_i ? hit[0] : hit[i];
        if (i == 0) begin : g_lead
            assign req_eff[i] = gang_mode_i ? req_any : (pwr_req_i[i] && active[i]);
        end else begin : g_rest
            assign req_eff[i] = !gang_mode_i && pwr_req_i[i] && active[i];
        end
        assign pwr_en_o[i] = pwr_pol_i ? pwr_on[i] : !pwr_on[i];

        hpl_oc_filter #(.FW(FW)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .oc_n  (oc_n_i[i]),
            .len   (oc_filt_i),
            .hit   (hit[i])
        );

        hpl_port_ctl u_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active[i]),
            .suspend (suspend_i),
            .req_eff (req_eff[i]),
            .oc_eff  (oc_eff[i]),
            .conn    (conn_i[i]),
            .enab    (enab_i[i]),
            .err     (err_i[i]),
            .man     (led_man_i[i]),
            .cmd     (led_cmd_i[2*i+1:2*i]),
            .clr     (oc_chg_clr_i[i]),
            .pwr_on  (pwr_on[i]),
            .green   (led_green_o[i]),
            .amber   (led_amber_o[i]),
            .chg     (oc_chg_o[i])
        );
    end
endmodule

// File: rtl/hpl_port_power_led_chk.sv
// Port-level temporal checks for the power and lamp controller.
module hpl_port_power_led_chk #(
    parameter int NPORT = 4,
    parameter int FW    = 8,
    localparam int CW   = $clog2(NPORT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gang_mode_i,
    input logic               pwr_pol_i,
    input logic [CW-1:0]      port_cnt_i,
    input logic               suspend_i,
    input logic [NPORT-1:0]   oc_chg_clr_i,
    input logic [NPORT-1:0]   pwr_en_o,
    input logic [NPORT-1:0]   led_green_o,
    input logic [NPORT-1:0]   led_amber_o,
    input logic [NPORT-1:0]   oc_chg_o
);
    assert_suspend_dark_R11: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |=> (led_green_o == '0 && led_amber_o == '0));

    assert_one_colour_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (led_green_o & led_amber_o) == '0);

    assert_gang_spares_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gang_mode_i |=> (pwr_en_o[NPORT-1:1] == {(NPORT-1){!pwr_pol_i}}));

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        assert_inactive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (port_cnt_i >= CW'(2) && CW'(i) >= port_cnt_i)
            |=> (pwr_en_o[i] == !pwr_pol_i && !led_green_o[i] && !led_amber_o[i]));

        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (oc_chg_o[i] && !oc_chg_clr_i[i]) |=> oc_chg_o[i]);
    end
endmodule

bind hpl_port_power_led hpl_port_power_led_chk #(.NPORT(NPORT), .FW(FW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gang_mode_i  (gang_mode_i),
    .pwr_pol_i    (pwr_pol_i),
    .port_cnt_i   (port_cnt_i),
    .suspend_i    (suspend_i),
    .oc_chg_clr_i (oc_chg_clr_i),
    .pwr_en_o     (pwr_en_o),
    .led_green_o  (led_green_o),
    .led_amber_o  (led_amber_o),
    .oc_chg_o     (oc_chg_o)
);

// File: tb/hpl_port_power_led_tb.sv
`timescale 1ns/1ps
module hpl_port_power_led_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         gang = 1'b0, pol = 1'b1, susp = 1'b0;
    logic [2:0]   pcnt = 3'd4;
    logic [7:0]   filt = 8'd5;
    logic [N-1:0] req = '0, conn = '0, enab = '0, err = '0, ocn = '1, clr = '0, man = '0;
    logic [2*N-1:0] cmd = '0;
    logic [N-1:0] pwr, grn, amb, chg;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    hpl_port_power_led u_dut (
        .clk(clk), .rst_n(rst_n), .gang_mode_i(gang), .pwr_pol_i(pol),
        .port_cnt_i(pcnt), .oc_filt_i(filt), .suspend_i(susp),
        .pwr_req_i(req), .conn_i(conn), .enab_i(enab), .err_i(err),
        .oc_n_i(ocn), .oc_chg_clr_i(clr), .led_man_i(man), .led_cmd_i(cmd),
        .pwr_en_o(pwr), .led_green_o(grn), .led_amber_o(amb), .oc_chg_o(chg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int eff_cnt(input logic [2:0] c);
        if (c < 2) return 2;
        if (c > N) return N;
        return int'(c);
    endfunction

    // expected enables with no over-current present (R2, R3, R4, R5)
    function automatic logic [N-1:0] exp_pwr(input logic g, input logic p,
                                             input logic [2:0] c, input logic [N-1:0] r);
        logic [N-1:0] on;
        logic [N-1:0] act;
        for (int i = 0; i < N; i++) act[i] = (i < eff_cnt(c));
        on = '0;
        if (g) on[0] = |(r & act);
        else   on = r & act;
        return p ? on : ~on;
    endfunction

    // expected {green, amber} with no over-current present (R5, R9, R10, R11)
    function automatic logic [2*N-1:0] exp_led(input logic s, input logic [2:0] c,
            input logic [N-1:0] m, input logic [2*N-1:0] k, input logic [N-1:0] e,
            input logic [N-1:0] cn, input logic [N-1:0] en);
        logic [N-1:0] g, a;
        g = '0; a = '0;
        for (int i = 0; i < N; i++) begin
            if (s || i >= eff_cnt(c)) begin
            end else if (m[i]) begin
                g[i] = (k[2*i +: 2] == 2'b01);
                a[i] = (k[2*i +: 2] == 2'b10);
            end else if (e[i]) a[i] = 1'b1;
            else if (cn[i] && en[i]) g[i] = 1'b1;
        end
        return {g, a};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        req = '1; conn = '1; enab = '1;
        cyc(4);
        // R1: state held in reset
        chk("R1 pwr in reset", pwr, '0);
        chk("R1 lamps in reset", {grn, amb}, '0);
        chk("R1 flags in reset", chg, '0);
        rst_n = 1'b1;

        // random phase, no over-current (R2..R5, R9..R11)
        for (int it = 0; it < 400; it++) begin
            gang = 1'($urandom); pol = 1'($urandom); susp = ($urandom % 6) == 0;
            pcnt = 3'($urandom); req = N'($urandom); conn = N'($urandom);
            enab = N'($urandom); err = N'($urandom); man = N'($urandom);
            cmd = (2*N)'($urandom); clr = N'($urandom);
            cyc(1);
            chk("R2/R3/R4/R5 enables", pwr, exp_pwr(gang, pol, pcnt, req));
            chk("R9/R10/R11/R5 lamps", {grn, amb},
                exp_led(susp, pcnt, man, cmd, err, conn, enab));
            chk("R8 no flag without fault", chg, '0);
        end

        // directed over-current, individual mode
        gang = 0; pol = 1; susp = 0; pcnt = 4; filt = 5; req = '1;
        conn = '1; enab = '1; err = '0; man = '0; clr = '0;
        cyc(3);
        chk("R3 all powered", pwr, 4'b1111);
        ocn[2] = 0; cyc(3); ocn[2] = 1; cyc(10);
        chk("R6 short pulse ignored pwr", pwr, 4'b1111);
        chk("R6 short pulse ignored flag", chg, 4'b0000);
        ocn[2] = 0; cyc(20);
        chk("R7 port 2 tripped", pwr, 4'b1011);
        chk("R8 flag 2 set", chg, 4'b0100);
        chk("R9 amber on fault", amb, 4'b0100);
        chk("R9 green elsewhere", grn, 4'b1011);
        ocn[2] = 1; cyc(10);
        chk("R7 stays off after fault", pwr, 4'b1011);
        chk("R9 green once fault gone", grn, 4'b1111);
        chk("R8 flag held", chg, 4'b0100);
        clr[2] = 1; cyc(1); clr[2] = 0; cyc(2);
        chk("R8 flag cleared", chg, 4'b0000);
        req[2] = 0; cyc(2); req[2] = 1; cyc(3);
        chk("R7 released by request drop", pwr, 4'b1111);

        filt = 1;
        ocn[1] = 0; cyc(1); ocn[1] = 1; cyc(8);
        chk("R6 one sample below threshold", pwr, 4'b1111);
        ocn[1] = 0; cyc(2); ocn[1] = 1; cyc(8);
        chk("R6 threshold reached trips", pwr, 4'b1101);
        chk("R8 flag 1 set", chg, 4'b0010);
        clr = '1; req = '0; cyc(2); clr = '0; req = '1; cyc(3);

        // directed over-current, gang mode
        gang = 1; filt = 5; cyc(3);
        chk("R4 shared enable", pwr, 4'b0001);
        ocn[3] = 0; cyc(20); ocn[3] = 1; cyc(8);
        chk("R4 other flags ignored in gang", pwr, 4'b0001);
        chk("R8 no flag from port 3 in gang", chg, 4'b0000);
        ocn[0] = 0; cyc(20);
        chk("R7 gang trip", pwr, 4'b0000);
        chk("R8 gang sets all flags", chg, 4'b1111);
        chk("R9 gang fault amber", amb, 4'b1111);
        ocn[0] = 1; cyc(8);
        req = 4'b0100; cyc(3);
        chk("R7 gang holds while any request", pwr, 4'b0000);
        req = '0; cyc(2); req = '1; cyc(3);
        chk("R7 gang released", pwr, 4'b0001);
        pol = 0; cyc(1);
        chk("R2 active-low shared enable", pwr, 4'b1110);

        // suspend darkens manual lamps
        man = '1; cmd = 8'b01010101; susp = 1; cyc(2);
        chk("R11 suspend dark", {grn, amb}, '0);
        susp = 0; cyc(2);
        chk("R10 manual green", grn, 4'b1111);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule